// File: doc/BRIEF.md
# Compare Flags and Conditional Jump Unit

This unit turns an 8-bit comparison into a set of stored branch predicates and decides whether the program counter is loaded. The first operand minus the second operand is computed modulo 256. From the sign bit and the zero test of that difference, six predicate bits are derived: equal, not equal, less, less-or-equal, greater, and greater-or-equal. On a clock edge where the store enable is high, these bits are captured into the upper byte of the output register. They hold there until the next store.

A later microinstruction supplies a 3-bit condition code, taken from the low bits of the instruction byte, and a jump enable. The unit keeps evaluating the selected condition against the stored predicates. It raises the PC load strobe only when the jump enable is also high. The branch target passes straight through to the PC input, so the strobe alone decides whether it is taken.

Top module: `cmp_jump_unit`

## Requirements
- R1: The difference is op_a_i minus op_b_i modulo 256. Negative means bit 7 of the difference is 1. Zero means the difference is 0x00.
- R2: Bit layout of flags_hi_o: bit 0 = zero, bit 1 = not zero, bit 2 = negative, bit 3 = negative or zero, bit 4 = neither negative nor zero, bit 5 = zero or not negative. Bits 7:6 are always 0.
- R3: On a rising clk_i edge with store_en_i high, flags_hi_o takes the predicates of the operands present at that edge. The new value is visible after the edge and not before it.
- R4: On a rising edge with store_en_i low, flags_hi_o keeps its value, whatever the operands are.
- R5: While rst_ni is low, flags_hi_o is 0x00. The reset is asynchronous and takes effect without waiting for a clock edge.
- R6: For cond_sel_i codes 0 to 5, pc_load_o equals jump_en_i AND bit [code] of the stored flags_hi_o, in the same cycle. It does not depend on the live operands.
- R7: Code 6 makes pc_load_o equal jump_en_i (always taken). Code 7 keeps pc_load_o low (never taken).
- R8: With jump_en_i low, pc_load_o is 0 for every condition code and every flag state.
- R9: pc_target_o always equals target_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 8 | First comparison operand |
| op_b_i | input | 8 | Second operand, subtracted from the first |
| store_en_i | input | 1 | Capture the predicates into the upper output byte |
| cond_sel_i | input | 3 | Condition code from the instruction low bits |
| jump_en_i | input | 1 | Decode-supplied permission to modify the PC |
| target_i | input | 16 | Branch target address |
| flags_hi_o | output | 8 | Upper output register byte holding the predicates |
| pc_load_o | output | 1 | PC load strobe |
| pc_target_o | output | 16 | Address presented to the PC |

## Verification
A wrong stored predicate shows on flags_hi_o one edge after the store, as a broken complement pair or a broken less/equal/greater trichotomy. It also shows at once on pc_load_o when any condition code reads that bit with the jump enabled. A register that updates without a store, or that fails to update on a store, is exposed by holding the operands at values that would give a different byte and then reading both flags_hi_o and the strobe. A select path that ignores the jump enable, or that swaps codes, is exposed by sweeping all eight codes against each known flag pattern.

// File: rtl/cmp_jump_pkg.sv
package cmp_jump_pkg;
  localparam int unsigned FLAG_N = 6;

  // Bit index of each predicate equals its condition code.
  typedef struct packed {
    logic ge;
    logic gt;
    logic le;
    logic lt;
    logic ne;
    logic eq;
  } cmp_flags_t;
endpackage

// File: rtl/cmp_flag_gen.sv
module cmp_flag_gen
  import cmp_jump_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output cmp_flags_t        flags_o
);
  logic [DATA_W-1:0] diff;
  logic              neg, zero;

  always_comb begin
    diff = op_a_i - op_b_i;
    neg  = diff[DATA_W-1];
    zero = (diff == '0);
    flags_o.eq = zero;
    flags_o.ne = ~zero;
    flags_o.lt = neg;
    flags_o.le = neg | zero;
    flags_o.gt = ~neg & ~zero;
    flags_o.ge = zero | ~neg;
  end
endmodule

// File: rtl/cmp_flag_reg.sv
module cmp_flag_reg
  import cmp_jump_pkg::*;
#(
  parameter int unsigned HI_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  cmp_flags_t      d_i,
  output logic [HI_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= HI_W'(d_i);
  end
endmodule

// File: rtl/cond_select.sv
module cond_select #(
  parameter int unsigned FLAG_N = 6,
  parameter int unsigned SEL_W  = 3
) (
  input  logic [FLAG_N-1:0] flags_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              jump_en_i,
  output logic              pc_load_o
);
  localparam int unsigned CODE_N = 1 << SEL_W;

  logic [CODE_N-1:0] cond;

  // Codes below FLAG_N read a predicate, FLAG_N is always taken, the rest never.
  for (genvar i = 0; i < CODE_N; i++) begin : g_code
    if (i < FLAG_N) begin : g_flag
      assign cond[i] = flags_i[i];
    end else if (i == FLAG_N) begin : g_always
      assign cond[i] = 1'b1;
    end else begin : g_never
      assign cond[i] = 1'b0;
    end
  end

  assign pc_load_o = jump_en_i & cond[sel_i];
endmodule

// File: rtl/cmp_jump_unit.sv
module cmp_jump_unit
  import cmp_jump_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              store_en_i,
  input  logic [SEL_W-1:0]  cond_sel_i,
  input  logic              jump_en_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [DATA_W-1:0] flags_hi_o,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_target_o
);
  cmp_flags_t live_flags;

  cmp_flag_gen #(.DATA_W(DATA_W)) u_gen (
    .op_a_i (op_a_i),
    .op_b_i (op_b_i),
    .flags_o(live_flags)
  );

  cmp_flag_reg #(.HI_W(DATA_W)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(store_en_i),
    .d_i   (live_flags),
    .q_o   (flags_hi_o)
  );

  // Jump decision reads the stored byte, never the live operands.
  cond_select #(.FLAG_N(FLAG_N), .SEL_W(SEL_W)) u_sel (
    .flags_i  (flags_hi_o[FLAG_N-1:0]),
    .sel_i    (cond_sel_i),
    .jump_en_i(jump_en_i),
    .pc_load_o(pc_load_o)
  );

  assign pc_target_o = target_i;
endmodule

// File: rtl/cmp_jump_unit_chk.sv
module cmp_jump_unit_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned SEL_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic              store_en_i,
  input logic [SEL_W-1:0]  cond_sel_i,
  input logic              jump_en_i,
  input logic [ADDR_W-1:0] target_i,
  input logic [DATA_W-1:0] flags_hi_o,
  input logic              pc_load_o,
  input logic [ADDR_W-1:0] pc_target_o
);
  localparam int unsigned FLAG_N = 6;

  logic [DATA_W-1:0] diff_w;
  logic              seen_store;

  assign diff_w = op_a_i - op_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         seen_store <= 1'b0;
    else if (store_en_i) seen_store <= 1'b1;
  end

  a_r5_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> flags_hi_o == '0);

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_en_i |=> $stable(flags_hi_o));

  a_r3_eq_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_en_i |=> flags_hi_o[0] == ($past(op_a_i) == $past(op_b_i)));

  a_r1_neg_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_en_i |=> flags_hi_o[2] == $past(diff_w[DATA_W-1]));

  a_r2_trichotomy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_store |-> $countones({flags_hi_o[0], flags_hi_o[2], flags_hi_o[4]}) == 1);

  a_r2_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_store |-> (flags_hi_o[1] == !flags_hi_o[0]) &&
                   (flags_hi_o[3] == (flags_hi_o[2] | flags_hi_o[0])) &&
                   (flags_hi_o[5] == !flags_hi_o[2]));

  a_r2_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_hi_o >> FLAG_N) == '0);

  a_r8_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jump_en_i |-> !pc_load_o);

  a_r7_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_en_i && cond_sel_i == SEL_W'(FLAG_N)) |-> pc_load_o);

  a_r7_never: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_sel_i == SEL_W'(FLAG_N + 1)) |-> !pc_load_o);

  a_r6_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_en_i && cond_sel_i < SEL_W'(FLAG_N)) |-> pc_load_o == flags_hi_o[cond_sel_i]);

  a_r9_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_target_o == target_i);
endmodule

bind cmp_jump_unit cmp_jump_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_a_i     (op_a_i),
  .op_b_i     (op_b_i),
  .store_en_i (store_en_i),
  .cond_sel_i (cond_sel_i),
  .jump_en_i  (jump_en_i),
  .target_i   (target_i),
  .flags_hi_o (flags_hi_o),
  .pc_load_o  (pc_load_o),
  .pc_target_o(pc_target_o)
);

// File: tb/cmp_jump_unit_tb.sv
module cmp_jump_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {op_a, op_b, expected flags_hi_o}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h05, 8'h05, 8'h29},
    {8'h07, 8'h03, 8'h32},
    {8'h03, 8'h07, 8'h0E},
    {8'h00, 8'h00, 8'h29},
    {8'h80, 8'h00, 8'h0E},
    {8'h00, 8'h80, 8'h0E},
    {8'hFF, 8'h00, 8'h0E},
    {8'h00, 8'hFF, 8'h32},
    {8'h7F, 8'h00, 8'h32},
    {8'hFF, 8'hFF, 8'h29}
  };

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [7:0]  op_a, op_b;
  logic        store_en, jump_en;
  logic [2:0]  cond_sel;
  logic [15:0] target;
  logic [7:0]  flags_hi;
  logic        pc_load;
  logic [15:0] pc_target;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmp_jump_unit u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .op_a_i     (op_a),
    .op_b_i     (op_b),
    .store_en_i (store_en),
    .cond_sel_i (cond_sel),
    .jump_en_i  (jump_en),
    .target_i   (target),
    .flags_hi_o (flags_hi),
    .pc_load_o  (pc_load),
    .pc_target_o(pc_target)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected strobe for a given stored byte (R6, R7)
  function automatic logic exp_load(input logic [7:0] f, input logic [2:0] s, input logic en);
    if (!en) return 1'b0;
    if (s < 3'd6) return f[s];
    return (s == 3'd6);
  endfunction

  task automatic sweep_sel(input logic [7:0] f);
    for (int s = 0; s < 8; s++) begin
      cond_sel = 3'(s);
      jump_en  = 1'b1;
      #1;
      chk($sformatf("R6/R7 sel=%0d", s), {15'd0, pc_load}, {15'd0, exp_load(f, 3'(s), 1'b1)});
      jump_en = 1'b0;
      #1;
      chk($sformatf("R8 sel=%0d", s), {15'd0, pc_load}, 16'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; op_a = '0; op_b = '0; store_en = 1'b0;
    jump_en = 1'b0; cond_sel = '0; target = '0;
    repeat (3) @(negedge clk);
    chk("R5 flags in reset", {8'd0, flags_hi}, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R5 flags after reset", {8'd0, flags_hi}, 16'h0000);
    cond_sel = 3'd6; jump_en = 1'b1; #1;
    chk("R7 always from reset", {15'd0, pc_load}, 16'd1);
    cond_sel = 3'd0; #1;
    chk("R6 eq from reset flags", {15'd0, pc_load}, 16'd0);
    jump_en = 1'b0;

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      op_a = VEC[i][23:16]; op_b = VEC[i][15:8]; store_en = 1'b1;
      target = {VEC[i][23:16], VEC[i][15:8]};
      #1;
      chk($sformatf("R9 target vec%0d", i), pc_target, {VEC[i][23:16], VEC[i][15:8]});
      @(negedge clk);
      store_en = 1'b0;
      chk($sformatf("R1/R2/R3 flags vec%0d", i), {8'd0, flags_hi}, {8'd0, VEC[i][7:0]});
      sweep_sel(VEC[i][7:0]);
    end

    // R4: hold with store low while operands change (stored 0x29 from last vector)
    @(negedge clk);
    op_a = 8'h03; op_b = 8'h07; store_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 hold flags", {8'd0, flags_hi}, 16'h0029);
    cond_sel = 3'd0; jump_en = 1'b1; #1;
    chk("R6 uses stored not live", {15'd0, pc_load}, 16'd1);
    cond_sel = 3'd2; #1;
    chk("R6 lt from stored", {15'd0, pc_load}, 16'd0);
    jump_en = 1'b0;

    // R3: new value not visible before the edge
    store_en = 1'b1; #1;
    chk("R3 no change before edge", {8'd0, flags_hi}, 16'h0029);
    @(posedge clk); #1;
    store_en = 1'b0;
    chk("R3 captured after edge", {8'd0, flags_hi}, 16'h000E);

    // R5: asynchronous clear between edges
    @(negedge clk); #2;
    rst_ni = 1'b0; #1;
    chk("R5 async clear", {8'd0, flags_hi}, 16'h0000);
    cond_sel = 3'd1; jump_en = 1'b1;
    @(negedge clk);
    rst_ni = 1'b1; #1;
    chk("R6 ne after clear", {15'd0, pc_load}, 16'd0);
    cond_sel = 3'd7; #1;
    chk("R7 never", {15'd0, pc_load}, 16'd0);
    jump_en = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule